// File: doc/BRIEF.md
# Event-Matrix PWM Timer

This block is a free-running up-counter that drives a bank of pulse outputs through a programmable event matrix. A set of match registers is compared against the counter. Each event watches one match register and fires when that register equals the counter. Every output has its own set mask and clear mask over the events, and its own rule for the case where a set and a clear reach it on the same step. A limit mask names the events that send the counter back to zero, and that choice fixes the period shared by all outputs.

A typical PWM setup gives one event a match value of N-1 and marks it in the limit mask, so the period is N counts. Each channel then uses one more event as its duty compare. A normal-polarity channel is set by the period event and cleared by its duty event; an inverted channel swaps the two. Every match register has a shadow reload register that is copied in at each limit hit, so new period and duty values take effect on a period boundary. A halt bit and an 8-bit prescaler control the count rate. A word-addressed write/read port holds all the configuration.

Top module: `evt_pwm_timer`

## Requirements
- R1: After reset the counter reads 0 and stays at 0, the control word reads 0x4 (halted, prescale 0), all outputs are low and every other register reads 0.
- R2: Address bits 7:4 pick a bank and bits 3:0 pick an entry. Bank 0 holds: entry 0 config (bit 0 unify flag, bit 7 no-reload), entry 1 control (bit 2 halt, bits 12:5 prescale), entry 2 limit mask (bit e = event e), entry 3 conflict rules, entry 4 the counter (read only). Bank 1 holds the match values, bank 2 the reload values, bank 3 the event controls (bits 3:0 match select, bits 13:12 trigger mode), bank 4 the set masks and bank 5 the clear masks. Bits that are not implemented read 0. A write takes effect at the next clock edge, and reads are combinational.
- R3: While halt is clear and the prescale value is P, the counter advances once every P+1 clocks. The first step lands P+1 clocks after the edge that wrote halt clear.
- R4: While halt is set the counter holds its value, no event fires and the outputs hold.
- R5: An event fires on a counter step only when its trigger mode is 1 and its selected match register equals the counter. Any other mode, including an all-zero control word, never fires.
- R6: When a fired event is in the limit mask, the counter's next value is 0 instead of count+1. A match value of N-1 on such an event gives a period of N steps.
- R7: A fired event in an output's set mask drives that output high, and one in its clear mask drives it low. The change appears at the same clock edge that moves the counter off the firing value.
- R8: When set and clear reach output n on the same step, conflict field bits 2n+1:2n decide the result: 0 keeps the old value, 1 sets, 2 clears, 3 toggles.
- R9: An output that gets no fired event through either mask keeps its value, so an output with both masks zero stays at its reset level.
- R10: At a limit hit with the no-reload bit clear, every match register takes its reload value. With the bit set, the match registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address: bank in bits 7:4, entry in bits 3:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NUM_OUT | Registered pulse outputs |

## Verification
A register write lands at the clock edge that samples the strobe. Once a write clears halt, a counter step falls on every (P+1)-th following edge. The outputs sit in registers that update on the same edge as the counter, so at any time they show the events that fired on the count value just left. The bench gives each clock a step index k, counted from the edge that released halt, and samples the counter and outputs at the falling edge after edge k. It works out the step count floor(k/(P+1)) and from it the expected count and output levels, so every check reads values that settled half a period earlier.

// File: rtl/evt_pwm_pkg.sv
package evt_pwm_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int PRE_W  = 8;

  // bank selectors (address bits 7:4)
  localparam logic [3:0] BANK_GLB    = 4'h0;
  localparam logic [3:0] BANK_MATCH  = 4'h1;
  localparam logic [3:0] BANK_RELOAD = 4'h2;
  localparam logic [3:0] BANK_EVCTL  = 4'h3;
  localparam logic [3:0] BANK_SETM   = 4'h4;
  localparam logic [3:0] BANK_CLRM   = 4'h5;

  // entries of the global bank
  localparam logic [3:0] GLB_CFG   = 4'h0;
  localparam logic [3:0] GLB_CTRL  = 4'h1;
  localparam logic [3:0] GLB_LIMIT = 4'h2;
  localparam logic [3:0] GLB_CONFL = 4'h3;
  localparam logic [3:0] GLB_COUNT = 4'h4;

  localparam int CFG_UNIFY_BIT    = 0;
  localparam int CFG_NORELOAD_BIT = 7;
  localparam int CTRL_HALT_BIT    = 2;
  localparam int CTRL_PRE_LSB     = 5;
  localparam int EV_MODE_LSB      = 12;

  localparam logic [1:0] EV_MODE_MATCH = 2'd1;

  typedef enum logic [1:0] {
    CR_HOLD   = 2'd0,
    CR_SET    = 2'd1,
    CR_CLEAR  = 2'd2,
    CR_TOGGLE = 2'd3
  } confl_e;

endpackage

// File: rtl/evt_pwm_regs.sv
module evt_pwm_regs
  import evt_pwm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 16,
  parameter int NUM_EVT   = 16,
  parameter int NUM_OUT   = 16,
  parameter int SEL_W     = $clog2(NUM_MATCH)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_we,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [DATA_W-1:0]                   reg_wdata,
  output logic [DATA_W-1:0]                   reg_rdata,
  input  logic [CNT_W-1:0]                    count,
  input  logic                                reload_now,
  output logic                                halt,
  output logic [PRE_W-1:0]                    pre_val,
  output logic                                no_reload,
  output logic [NUM_EVT-1:0]                  limit_mask,
  output logic [2*NUM_OUT-1:0]                confl,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]     match_val,
  output logic [NUM_EVT-1:0][SEL_W-1:0]       ev_sel,
  output logic [NUM_EVT-1:0][1:0]             ev_mode,
  output logic [NUM_OUT-1:0][NUM_EVT-1:0]     set_mask,
  output logic [NUM_OUT-1:0][NUM_EVT-1:0]     clr_mask
);

  logic [3:0]       bank;
  logic [IDX_W-1:0] idx;
  assign bank = reg_addr[7:4];
  assign idx  = reg_addr[IDX_W-1:0];

  // global bank
  logic               unify_q, unify_d;
  logic               norl_q, norl_d;
  logic               halt_q, halt_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [NUM_EVT-1:0] lim_q, lim_d;
  logic [2*NUM_OUT-1:0] cfl_q, cfl_d;

  always_comb begin
    unify_d = unify_q;
    norl_d  = norl_q;
    halt_d  = halt_q;
    pre_d   = pre_q;
    lim_d   = lim_q;
    cfl_d   = cfl_q;
    if (reg_we && bank == BANK_GLB) begin
      case (idx)
        GLB_CFG: begin
          unify_d = reg_wdata[CFG_UNIFY_BIT];
          norl_d  = reg_wdata[CFG_NORELOAD_BIT];
        end
        GLB_CTRL: begin
          halt_d = reg_wdata[CTRL_HALT_BIT];
          pre_d  = reg_wdata[CTRL_PRE_LSB +: PRE_W];
        end
        GLB_LIMIT: lim_d = reg_wdata[NUM_EVT-1:0];
        GLB_CONFL: cfl_d = reg_wdata[2*NUM_OUT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unify_q <= 1'b0;
      norl_q  <= 1'b0;
      halt_q  <= 1'b1;
      pre_q   <= '0;
      lim_q   <= '0;
      cfl_q   <= '0;
    end else begin
      unify_q <= unify_d;
      norl_q  <= norl_d;
      halt_q  <= halt_d;
      pre_q   <= pre_d;
      lim_q   <= lim_d;
      cfl_q   <= cfl_d;
    end
  end

  assign halt       = halt_q;
  assign pre_val    = pre_q;
  assign no_reload  = norl_q;
  assign limit_mask = lim_q;
  assign confl      = cfl_q;

  // match values with their shadow reload registers
  logic [NUM_MATCH-1:0][CNT_W-1:0] reload_val;

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
    logic             wr_m, wr_r;
    logic [CNT_W-1:0] m_q, m_d, r_q, r_d;
    assign wr_m = reg_we && (bank == BANK_MATCH)  && (idx == IDX_W'(m));
    assign wr_r = reg_we && (bank == BANK_RELOAD) && (idx == IDX_W'(m));
    always_comb begin
      m_d = m_q;
      if (wr_m)            m_d = reg_wdata[CNT_W-1:0];
      else if (reload_now) m_d = r_q;
      r_d = wr_r ? reg_wdata[CNT_W-1:0] : r_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '0;
        r_q <= '0;
      end else begin
        m_q <= m_d;
        r_q <= r_d;
      end
    end
    assign match_val[m]  = m_q;
    assign reload_val[m] = r_q;
  end

  // event controls
  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evctl
    logic             wr_e;
    logic [SEL_W-1:0] s_q, s_d;
    logic [1:0]       md_q, md_d;
    assign wr_e = reg_we && (bank == BANK_EVCTL) && (idx == IDX_W'(e));
    always_comb begin
      s_d  = wr_e ? reg_wdata[SEL_W-1:0] : s_q;
      md_d = wr_e ? reg_wdata[EV_MODE_LSB +: 2] : md_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q  <= '0;
        md_q <= '0;
      end else begin
        s_q  <= s_d;
        md_q <= md_d;
      end
    end
    assign ev_sel[e]  = s_q;
    assign ev_mode[e] = md_q;
  end

  // per-output set and clear masks
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_mask
    logic               wr_s, wr_c;
    logic [NUM_EVT-1:0] sm_q, sm_d, cm_q, cm_d;
    assign wr_s = reg_we && (bank == BANK_SETM) && (idx == IDX_W'(o));
    assign wr_c = reg_we && (bank == BANK_CLRM) && (idx == IDX_W'(o));
    always_comb begin
      sm_d = wr_s ? reg_wdata[NUM_EVT-1:0] : sm_q;
      cm_d = wr_c ? reg_wdata[NUM_EVT-1:0] : cm_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sm_q <= '0;
        cm_q <= '0;
      end else begin
        sm_q <= sm_d;
        cm_q <= cm_d;
      end
    end
    assign set_mask[o] = sm_q;
    assign clr_mask[o] = cm_q;
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (bank)
      BANK_GLB: begin
        case (idx)
          GLB_CFG: begin
            reg_rdata[CFG_UNIFY_BIT]    = unify_q;
            reg_rdata[CFG_NORELOAD_BIT] = norl_q;
          end
          GLB_CTRL: begin
            reg_rdata[CTRL_HALT_BIT]            = halt_q;
            reg_rdata[CTRL_PRE_LSB +: PRE_W]    = pre_q;
          end
          GLB_LIMIT: reg_rdata[NUM_EVT-1:0]   = lim_q;
          GLB_CONFL: reg_rdata[2*NUM_OUT-1:0] = cfl_q;
          GLB_COUNT: reg_rdata[CNT_W-1:0]     = count;
          default: ;
        endcase
      end
      BANK_MATCH: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (idx == IDX_W'(i)) reg_rdata[CNT_W-1:0] = match_val[i];
      end
      BANK_RELOAD: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (idx == IDX_W'(i)) reg_rdata[CNT_W-1:0] = reload_val[i];
      end
      BANK_EVCTL: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (idx == IDX_W'(i)) begin
            reg_rdata[SEL_W-1:0]         = ev_sel[i];
            reg_rdata[EV_MODE_LSB +: 2]  = ev_mode[i];
          end
      end
      BANK_SETM: begin
        for (int i = 0; i < NUM_OUT; i++)
          if (idx == IDX_W'(i)) reg_rdata[NUM_EVT-1:0] = set_mask[i];
      end
      BANK_CLRM: begin
        for (int i = 0; i < NUM_OUT; i++)
          if (idx == IDX_W'(i)) reg_rdata[NUM_EVT-1:0] = clr_mask[i];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/evt_pwm_counter.sv
module evt_pwm_counter
  import evt_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [PRE_W-1:0] pre_val,
  input  logic             lim_hit,
  output logic             tick,
  output logic [CNT_W-1:0] count
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a step is due when the prescale counter reaches its terminal value
  assign tick = !halt && (pre_q >= pre_val);

  always_comb begin
    pre_d = pre_q;
    if (halt || tick) pre_d = '0;
    else              pre_d = pre_q + PRE_W'(1);
    cnt_d = cnt_q;
    if (tick) cnt_d = lim_hit ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/evt_pwm_events.sv
module evt_pwm_events
  import evt_pwm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 16,
  parameter int NUM_EVT   = 16,
  parameter int SEL_W     = $clog2(NUM_MATCH)
) (
  input  logic                            tick,
  input  logic [CNT_W-1:0]                count,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_val,
  input  logic [NUM_EVT-1:0][SEL_W-1:0]   ev_sel,
  input  logic [NUM_EVT-1:0][1:0]         ev_mode,
  output logic [NUM_EVT-1:0]              fired
);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    logic [CNT_W-1:0] watched;
    assign watched  = match_val[ev_sel[e]];
    assign fired[e] = tick && (ev_mode[e] == EV_MODE_MATCH) && (watched == count);
  end

endmodule

// File: rtl/evt_pwm_outputs.sv
module evt_pwm_outputs
  import evt_pwm_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int NUM_OUT = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_EVT-1:0]              fired,
  input  logic [NUM_OUT-1:0][NUM_EVT-1:0] set_mask,
  input  logic [NUM_OUT-1:0][NUM_EVT-1:0] clr_mask,
  input  logic [2*NUM_OUT-1:0]            confl,
  output logic [NUM_OUT-1:0]              set_hit,
  output logic [NUM_OUT-1:0]              clr_hit,
  output logic [NUM_OUT-1:0]              out
);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic   o_q, o_d;
    confl_e rule;
    assign set_hit[o] = |(fired & set_mask[o]);
    assign clr_hit[o] = |(fired & clr_mask[o]);
    assign rule       = confl_e'(confl[2*o +: 2]);

    always_comb begin
      o_d = o_q;
      case ({set_hit[o], clr_hit[o]})
        2'b10: o_d = 1'b1;
        2'b01: o_d = 1'b0;
        2'b11: begin
          case (rule)
            CR_SET:    o_d = 1'b1;
            CR_CLEAR:  o_d = 1'b0;
            CR_TOGGLE: o_d = ~o_q;
            default:   o_d = o_q;
          endcase
        end
        default: o_d = o_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_q <= 1'b0;
      else        o_q <= o_d;
    end

    assign out[o] = o_q;
  end

endmodule

// File: rtl/evt_pwm_timer.sv
module evt_pwm_timer
  import evt_pwm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 16,
  parameter int NUM_EVT   = 16,
  parameter int NUM_OUT   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_OUT-1:0] pwm_out
);

  localparam int SEL_W = $clog2(NUM_MATCH);

  // reset: asserted at once, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                            halt_w, no_reload_w, tick_w, lim_hit_w, reload_now_w;
  logic [PRE_W-1:0]                pre_w;
  logic [NUM_EVT-1:0]              limit_w, fired_w;
  logic [2*NUM_OUT-1:0]            confl_w;
  logic [CNT_W-1:0]                count_w;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_w;
  logic [NUM_EVT-1:0][SEL_W-1:0]   sel_w;
  logic [NUM_EVT-1:0][1:0]         mode_w;
  logic [NUM_OUT-1:0][NUM_EVT-1:0] setm_w, clrm_w;
  logic [NUM_OUT-1:0]              set_hit_w, clr_hit_w;

  assign lim_hit_w    = |(fired_w & limit_w);
  assign reload_now_w = tick_w && lim_hit_w && !no_reload_w;

  evt_pwm_regs #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_EVT(NUM_EVT),
    .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(count_w), .reload_now(reload_now_w),
    .halt(halt_w), .pre_val(pre_w), .no_reload(no_reload_w),
    .limit_mask(limit_w), .confl(confl_w), .match_val(match_w),
    .ev_sel(sel_w), .ev_mode(mode_w), .set_mask(setm_w), .clr_mask(clrm_w)
  );

  evt_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .halt(halt_w), .pre_val(pre_w),
    .lim_hit(lim_hit_w), .tick(tick_w), .count(count_w)
  );

  evt_pwm_events #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)
  ) u_evt (
    .tick(tick_w), .count(count_w), .match_val(match_w),
    .ev_sel(sel_w), .ev_mode(mode_w), .fired(fired_w)
  );

  evt_pwm_outputs #(.NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .fired(fired_w),
    .set_mask(setm_w), .clr_mask(clrm_w), .confl(confl_w),
    .set_hit(set_hit_w), .clr_hit(clr_hit_w), .out(pwm_out)
  );

endmodule

// File: rtl/evt_pwm_chk.sv
module evt_pwm_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16,
  parameter int NUM_OUT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               halt,
  input logic               tick,
  input logic               lim_hit,
  input logic [CNT_W-1:0]   count,
  input logic [NUM_EVT-1:0] fired,
  input logic [NUM_OUT-1:0] set_hit,
  input logic [NUM_OUT-1:0] clr_hit,
  input logic [NUM_OUT-1:0] out
);

  assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(count));

  assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (fired == '0));

  assert_fire_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fired) |-> tick);

  assert_limit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim_hit) |=> (count == '0));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !lim_hit) |=> (count == $past(count) + CNT_W'(1)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_set_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_hit & ~clr_hit)) |=>
      ((out & $past(set_hit & ~clr_hit)) == $past(set_hit & ~clr_hit)));

  assert_clr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_hit & ~set_hit)) |=> ((out & $past(clr_hit & ~set_hit)) == '0));

  assert_no_hit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_hit | clr_hit) == '0) |=> $stable(out));

endmodule

bind evt_pwm_timer evt_pwm_chk #(
  .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .halt(halt_w), .tick(tick_w),
  .lim_hit(lim_hit_w), .count(count_w), .fired(fired_w),
  .set_hit(set_hit_w), .clr_hit(clr_hit_w), .out(pwm_out)
);

// File: tb/evt_pwm_timer_tb.sv
`timescale 1ns/1ps
module evt_pwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] pwm_out;
  int          n_chk  = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  evt_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  localparam logic [7:0] AD_CFG = 8'h00, AD_CTRL = 8'h01, AD_LIM = 8'h02,
                         AD_CFL = 8'h03, AD_CNT = 8'h04;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = AD_CNT;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = AD_CNT;
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = AD_CNT; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // PWM channel on output 0: event 0 = period (match 0 = 7), event 1 = duty (match 1 = d)
  task automatic run_pwm(input int p, input int d, input int pol);
    int t, c;
    logic e;
    do_reset;
    wr(8'h10, 32'd7); wr(8'h20, 32'd7);
    wr(8'h11, 32'(d)); wr(8'h21, 32'(d));
    wr(8'h30, 32'h1000); wr(8'h31, 32'h1001);
    wr(AD_LIM, 32'h1);
    wr(8'h40, (pol != 0) ? 32'd2 : 32'd1);
    wr(8'h50, (pol != 0) ? 32'd1 : 32'd2);
    wr(AD_CFL, (pol != 0) ? 32'd2 : 32'd1);
    wr(AD_CTRL, 32'(p) << 5);
    for (int k = 1; k <= 24 * (p + 1); k++) begin
      @(negedge clk); #1;
      t = k / (p + 1);
      c = t % 8;
      if (pol == 0) e = (t >= 8) && (c <= d);
      else          e = (d != 7) && (c > d);
      chk("R3 R6 counter value", reg_rdata, 32'(c));
      chk("R7 R8 output 0 level", {31'b0, pwm_out[0]}, {31'b0, e});
      chk("R9 unused outputs", {17'b0, pwm_out[15:1]}, 32'b0);
    end
  endtask

  task automatic run_conflict;
    int t, w;
    logic [15:0] ex;
    logic [31:0] c0, r;
    logic [15:0] o0;
    do_reset;
    wr(8'h10, 32'd3); wr(8'h20, 32'd3);
    wr(8'h12, 32'd2); wr(8'h22, 32'd2);
    wr(8'h30, 32'h1000);
    wr(8'h33, 32'h2002);            // mode 2: never fires
    wr(8'h34, 32'h1002);            // watches match 2
    wr(AD_LIM, 32'h1);
    for (int o = 1; o <= 4; o++) begin
      wr(8'h40 + 8'(o), 32'h1);
      wr(8'h50 + 8'(o), 32'h1);
    end
    wr(8'h46, 32'h4);               // event 2 has a zero control word
    wr(8'h47, 32'h8);
    wr(8'h48, 32'h10);
    wr(AD_CFL, (32'd3 << 2) | (32'd0 << 4) | (32'd1 << 6) | (32'd2 << 8));
    wr(AD_CTRL, 32'h0);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk); #1;
      t = k;
      w = t / 4;
      ex = '0;
      ex[1] = (w % 2) == 1;
      ex[3] = (w >= 1);
      ex[8] = (t >= 3);
      chk("R8 conflict rules, R5 R9 disabled events", {16'b0, pwm_out}, {16'b0, ex});
      chk("R6 period 4 counter", reg_rdata, 32'(t % 4));
    end
    wr(AD_CTRL, 32'h4);
    rd(AD_CNT, c0);
    o0 = pwm_out;
    repeat (20) @(negedge clk);
    #1;
    rd(AD_CNT, r);
    chk("R4 halted counter holds", r, c0);
    chk("R4 halted outputs hold", {16'b0, pwm_out}, {16'b0, o0});
  endtask

  task automatic run_reload(input int nr);
    int t, c;
    logic [31:0] r;
    do_reset;
    wr(AD_CFG, (32'(nr) << 7) | 32'h1);
    wr(8'h10, 32'd7); wr(8'h20, 32'd3);
    wr(8'h30, 32'h1000);
    wr(AD_LIM, 32'h1);
    wr(AD_CTRL, 32'h0);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk); #1;
      t = k;
      if (nr != 0)   c = t % 8;
      else if (t < 8) c = t;
      else            c = (t - 8) % 4;
      chk("R10 counter with reload setting", reg_rdata, 32'(c));
    end
    wr(AD_CTRL, 32'h4);
    rd(8'h10, r);
    chk("R10 match 0 after limit", r, (nr != 0) ? 32'd7 : 32'd3);
  endtask

  task automatic run_readback;
    logic [31:0] r;
    do_reset;
    rd(AD_CTRL, r); chk("R1 control after reset", r, 32'h4);
    rd(AD_CFG, r);  chk("R1 config after reset", r, 32'h0);
    rd(AD_LIM, r);  chk("R1 limit after reset", r, 32'h0);
    rd(8'h1F, r);   chk("R1 match 15 after reset", r, 32'h0);
    rd(8'h35, r);   chk("R1 event control after reset", r, 32'h0);
    chk("R1 outputs after reset", {16'b0, pwm_out}, 32'h0);
    repeat (10) @(negedge clk);
    #1 rd(AD_CNT, r); chk("R1 counter stays 0", r, 32'h0);
    wr(AD_CFG, 32'hFFFF_FFFF);
    wr(AD_CTRL, 32'hFFFF_FFFF);
    wr(AD_LIM, 32'hFFFF_FFFF);
    wr(AD_CFL, 32'hA5A5_1234);
    wr(8'h15, 32'hDEAD_BEEF);
    wr(8'h29, 32'h1234_5678);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h42, 32'hFFFF_ABCD);
    wr(8'h5E, 32'h0000_1357);
    rd(AD_CFG, r);  chk("R2 config bits", r, 32'h81);
    rd(AD_CTRL, r); chk("R2 control bits", r, 32'h1FE4);
    rd(AD_LIM, r);  chk("R2 limit mask", r, 32'hFFFF);
    rd(AD_CFL, r);  chk("R2 conflict word", r, 32'hA5A5_1234);
    rd(8'h15, r);   chk("R2 match 5", r, 32'hDEAD_BEEF);
    rd(8'h29, r);   chk("R2 reload 9", r, 32'h1234_5678);
    rd(8'h3C, r);   chk("R2 event control 12", r, 32'h300F);
    rd(8'h42, r);   chk("R2 set mask 2", r, 32'hABCD);
    rd(8'h5E, r);   chk("R2 clear mask 14", r, 32'h1357);
    rd(8'h14, r);   chk("R2 untouched match 4", r, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_addr = AD_CNT;
    reg_wdata = '0;
    run_readback;
    for (int pol = 0; pol < 2; pol++)
      for (int p = 0; p < 3; p++)
        for (int d = 0; d < 8; d++)
          run_pwm(p, d, pol);
    run_conflict;
    run_reload(0);
    run_reload(1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule